// File: doc/BRIEF.md
# Push-Step Signed Accumulator

This block keeps a wide two's-complement running total and adds one narrow signed sample to it only when asked to. It does not add every cycle. Each add comes from a pair of push-style inputs. A press on `go_i` lets exactly one accumulate step through. Further presses on `go_i` are then refused until `relatch_i` has been seen. So an operator, or a slow control agent, gets exactly one addition per press, however long the press lasts.

A three-state sequencer (idle, fire, hold) turns the press into a one-clock step enable. That enable acts as a clock enable on the total register, which is clocked by the same clock. The sample is sign-extended to the total's width and then added. The sum wraps on overflow. A synchronous clear zeroes the total, and an asynchronous active-low reset returns both the sequencer and the total to their start state.

Top module: `stepacc_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `total_o` is 0 and `step_o` is 0. The sequencer starts in idle.
- R2: In idle, `go_i` high at a rising edge moves the sequencer to fire. `step_o` is then high for exactly the following clock cycle.
- R3: After fire the sequencer always moves to hold. In hold, `go_i` has no effect: `step_o` stays 0 and `total_o` does not change.
- R4: In hold, `relatch_i` high at a rising edge returns the sequencer to idle. In idle, `relatch_i` has no effect.
- R5: At the rising edge that ends a cycle with `step_o` high, `total_o` becomes the old total plus `sample_i` sign-extended from its top bit. For example, -8 (`4'b1000`) added to 0 gives `8'hF8`, and adding -1 (`4'b1111`) next gives `8'hF7`.
- R6: The sum wraps modulo 2^ACC_W. Nothing saturates and no flag is raised. For example, nineteen steps of +7 from zero give `8'h85`.
- R7: `clr_i` high at a rising edge sets `total_o` to 0 after that edge, even if `step_o` is high in the same cycle.
- R8: When neither a step nor a clear happens at an edge, `total_o` holds its value.
- R9: Holding `go_i` high for many cycles from idle gives exactly one step until `relatch_i` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the sequencer and the total |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Press that requests one accumulate step |
| relatch_i | input | 1 | Press that re-enables `go_i` after a step |
| clr_i | input | 1 | Synchronous clear of the total |
| sample_i | input | IN_W | Two's-complement sample to add |
| total_o | output | ACC_W | Two's-complement running total |
| step_o | output | 1 | High during the one cycle whose closing edge adds the sample |

## Verification
The assertions assume that `go_i`, `relatch_i`, `clr_i` and `sample_i` are already synchronous to `clk` and settled at each rising edge. They also assume any value is legal in any state, so no ordering of presses is taken for granted. The stimulus changes inputs just after each edge. It draws presses and clears with biased random probabilities, so runs of held presses, presses in the wrong state and clears that land on a fire cycle all occur. The random draws are interleaved with directed sequences for the sign-extension example, wrap-around and the clear-beats-step case.

// File: rtl/stepacc_pkg.sv
package stepacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIRE = 2'd1,
    ST_HOLD = 2'd2
  } step_state_e;

endpackage

// File: rtl/stepacc_ctrl.sv
module stepacc_ctrl
  import stepacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic        relatch_i,
  output logic        step_o,
  output step_state_e state_o
);

  step_state_e state_q;
  step_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i)      state_d = ST_FIRE;
      ST_FIRE:                state_d = ST_HOLD;
      ST_HOLD: if (relatch_i) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign step_o  = (state_q == ST_FIRE);
  assign state_o = state_q;

  // R2: a press in idle yields a step on the next cycle
  assert_go_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && go_i) |=> step_o);

  // R2: the step is never longer than one cycle
  assert_step_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

  // R3: fire is always followed by hold
  assert_fire_to_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (state_o == ST_HOLD));

  // R3: no step can come out of hold without a relatch press
  assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HOLD && !relatch_i) |=> (state_o == ST_HOLD && !step_o));

  // R4: relatch in idle changes nothing
  assert_relatch_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && !go_i) |=> (state_o == ST_IDLE));

endmodule

// File: rtl/stepacc_acc.sv
module stepacc_acc #(
  parameter int IN_W  = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic [ACC_W-1:0] total_o
);

  localparam int EXT_W = ACC_W - IN_W;

  // sign-extend the narrow sample to the total's width
  function automatic logic [ACC_W-1:0] widen(input logic [IN_W-1:0] s);
    logic [ACC_W-1:0] r;
    r = '0;
    for (int i = 0; i < ACC_W; i++) begin
      r[i] = (i < IN_W) ? s[i] : s[IN_W-1];
    end
    return r;
  endfunction

  // modular add; the carry out of the top bit is dropped
  function automatic logic [ACC_W-1:0] wrap_add(input logic [ACC_W-1:0] a,
                                                input logic [IN_W-1:0]  s);
    return a + widen(s);
  endfunction

  logic [ACC_W-1:0] total_q;
  logic [ACC_W-1:0] sum_w;

  generate
    if (EXT_W > 0) begin : g_wide
      assign sum_w = wrap_add(total_q, sample_i);
    end else begin : g_narrow
      assign sum_w = total_q + sample_i[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total_q <= '0;
    else if (clr_i)  total_q <= '0;
    else if (en_i)   total_q <= sum_w;
  end

  assign total_o = total_q;

  // R7: clear wins over any step in the same cycle
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (total_o == '0));

  // R8: with neither clear nor step the total is held
  assert_hold_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(total_o));

  // R5: the sign of the added amount follows the sample's top bit
  assert_neg_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && en_i && sample_i[IN_W-1]) |=>
      ((total_o - $past(total_o)) >= widen({1'b1, {(IN_W-1){1'b0}}})));

  // R5: a zero sample leaves the total unchanged
  assert_zero_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && en_i && sample_i == '0) |=> $stable(total_o));

endmodule

// File: rtl/stepacc_top.sv
module stepacc_top
  import stepacc_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             relatch_i,
  input  logic             clr_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic [ACC_W-1:0] total_o,
  output logic             step_o
);

  logic        step_w;
  step_state_e state_w;

  stepacc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_i),
    .relatch_i (relatch_i),
    .step_o    (step_w),
    .state_o   (state_w)
  );

  stepacc_acc #(.IN_W(IN_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .en_i     (step_w),
    .sample_i (sample_i),
    .total_o  (total_o)
  );

  assign step_o = step_w;

  // R1: the first cycle out of reset is idle with a zero total
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (total_o == '0 && !step_o && state_w == ST_IDLE));

endmodule

// File: tb/stepacc_top_test.sv
module stepacc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, rel = 1'b0, clr = 1'b0;
  logic [IW-1:0] smp = '0;
  logic [AW-1:0] total;
  logic step;

  int n_vec = 0;
  int n_bad = 0;
  int m_state = 0;   // 0 idle, 1 fire, 2 hold
  int m_acc = 0;
  int steps_seen;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepacc_top #(.IN_W(IW), .ACC_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .relatch_i(rel), .clr_i(clr),
    .sample_i(smp), .total_o(total), .step_o(step)
  );

  function automatic int as_signed(input logic [IW-1:0] s);
    int v;
    v = int'(s);
    if (v >= (1 << (IW-1))) v = v - (1 << IW);
    return v;
  endfunction

  function automatic int modw(input int v);
    int m;
    m = v % (1 << AW);
    if (m < 0) m = m + (1 << AW);
    return m;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic a, input logic r, input logic c,
                     input logic [IW-1:0] s);
    int n_acc, n_state;
    go = a; rel = r; clr = c; smp = s;
    n_acc = m_acc;
    if (c) n_acc = 0;
    else if (m_state == 1) n_acc = modw(m_acc + as_signed(s));
    n_state = m_state;
    case (m_state)
      0: if (a) n_state = 1;
      1: n_state = 2;
      default: if (r) n_state = 0;
    endcase
    @(posedge clk); #1;
    m_acc = n_acc; m_state = n_state;
    if (step) steps_seen++;
    chk("R2/R3/R4/R9 step", int'(step), (m_state == 1) ? 1 : 0);
    chk("R5/R6/R7/R8 total", int'(total), m_acc);
  endtask

  task automatic one_step(input logic [IW-1:0] s);
    cyc(1, 0, 0, '0);
    cyc(0, 0, 0, s);
    cyc(0, 1, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    steps_seen = 0;
    #(CLK_PERIOD * 3 + 1);
    chk("R1 total in reset", int'(total), 0);
    chk("R1 step in reset", int'(step), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 total after reset", int'(total), 0);
    chk("R1 step after reset", int'(step), 0);

    // R4: relatch in idle is ignored
    repeat (3) cyc(0, 1, 0, 4'h3);
    chk("R4 idle relatch no step", steps_seen, 0);

    // R2 and R5: -8 then -1
    cyc(1, 0, 0, '0);
    chk("R2 step after go", int'(step), 1);
    cyc(0, 0, 0, 4'b1000);
    chk("R5 minus eight", int'(total), 8'hF8);
    chk("R2 step one cycle", int'(step), 0);
    // R3: go in hold ignored
    repeat (4) cyc(1, 0, 0, 4'h7);
    chk("R3 hold total kept", int'(total), 8'hF8);
    cyc(0, 1, 0, '0);
    cyc(1, 0, 0, '0);
    cyc(0, 0, 0, 4'b1111);
    chk("R5 minus one", int'(total), 8'hF7);
    cyc(0, 1, 0, '0);

    // R7: clear beats a step in the same cycle
    cyc(1, 0, 0, '0);
    cyc(0, 0, 1, 4'h5);
    chk("R7 clear over step", int'(total), 0);
    cyc(0, 1, 0, '0);

    // R6: wrap-around
    repeat (19) one_step(4'h7);
    chk("R6 wrap positive", int'(total), 8'h85);
    cyc(0, 0, 1, '0);
    repeat (17) one_step(4'h8);
    chk("R6 wrap negative", int'(total), 120);

    // R9: go held for a long time gives one step
    steps_seen = 0;
    repeat (12) cyc(1, 0, 0, 4'h2);
    chk("R9 held go single step", steps_seen, 1);
    cyc(0, 1, 0, '0);

    // R8 idle hold
    repeat (5) cyc(0, 0, 0, 4'h6);
    chk("R8 idle total kept", int'(total), m_acc);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 100) < 35, ($urandom % 100) < 30,
          ($urandom % 100) < 4, IW'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule